// File: doc/BRIEF.md
# Shared Command/Response Buffer Sequencer

This engine runs one command/response exchange through a byte buffer that it shares with a register front-end. Software places a command somewhere in the buffer, programs a command window and a response window as absolute bus addresses plus byte counts, and pulses `go`. The sequencer turns each address into a buffer offset by subtracting the buffer's base address. It rejects any window that does not fit inside the buffer. For a valid request it streams the command bytes to a backend over a valid/ready byte channel, then zeroes the whole buffer. It then takes the backend's response bytes and stores them at the response offset.

Completion is a single-cycle `done` pulse, which the front-end uses to clear its start bit. A rejected request raises `err` and completes at once. In that case the backend sees no traffic and the buffer is left as it was. While the engine is busy, host writes to the buffer are dropped, so the command cannot be changed after `go`. Host reads are always served, with one cycle of latency.

Top module: `cbs_seq`

## Requirements
- R1: Offset = address − `BASE` (32-bit, wrapping). A window is valid only when offset ≤ `DEPTH` and offset + size ≤ `DEPTH` (computed without overflow), for both windows. If either window is invalid, `go` gives `done` and `err` on the next cycle, no backend traffic, and an unchanged buffer.
- R2: For a valid request, the backend receives exactly command-size bytes, read in order from the command offset. `cmd_last` is high on the final byte only. A command size of zero sends no bytes.
- R3: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_data` and `cmd_last` hold their values.
- R4: Host buffer writes have no effect while `busy` is high. The bytes sent are the buffer contents at the time `go` was accepted.
- R5: After the command phase, every buffer byte is zeroed. Every byte outside the stored response reads zero after completion.
- R6: Response byte i is stored at response offset + i only while i < response size. Bytes beyond that count are dropped. The exchange ends on the handshake that carries `rsp_last`, and response bytes not supplied stay zero.
- R7: `done` is a single-cycle pulse with `busy` low. `err` rises only together with `done`, and is cleared by the next accepted valid request.
- R8: A `go` pulse while `busy` is high is ignored. No second exchange follows.
- R9: After reset, `busy`, `done`, `err`, `cmd_valid` and `rsp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse from the front-end |
| cmd_size | input | 32 | Command byte count |
| cmd_addr | input | 32 | Absolute command address |
| rsp_size | input | 32 | Response byte count |
| rsp_addr | input | 32 | Absolute response address |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Completion pulse; clears the start bit |
| err | output | 1 | Last request was rejected |
| hst_we | input | 1 | Host buffer write enable |
| hst_addr | input | AW | Host buffer byte index |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, one cycle after the address |
| cmd_valid | output | 1 | Command byte valid |
| cmd_ready | input | 1 | Backend accepts command byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final command byte |
| rsp_valid | input | 1 | Response byte valid |
| rsp_ready | output | 1 | Engine accepts response bytes |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |

## Verification
A wrong phase or index shows up at the backend ports within one transfer. Symptoms are a byte out of order, a misplaced `cmd_last`, a handshake outside the busy window, or a `done` that is missing or repeated. A scrub or response-placement fault stays hidden until the buffer is read back after `done`. The bench therefore reads every byte after every exchange and compares it against a model that holds the zeroed buffer with the response overlaid. Blocked-write faults show up either in the command stream, because a late write is injected into a byte not yet sent, or in the readback, because a write is injected during the response phase.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD_RD,
        PH_CMD_TX,
        PH_SCRUB,
        PH_RSP
    } phase_e;
endpackage

// File: rtl/cbs_window.sv
module cbs_window #(
    parameter logic [31:0] BASE  = 32'hFED4_0080,
    parameter int          DEPTH = 128,
    parameter int          IW    = $clog2(DEPTH + 1)
) (
    input  logic [31:0]   addr,
    input  logic [31:0]   size,
    output logic          ok,
    output logic [IW-1:0] off,
    output logic [IW-1:0] len
);
    localparam logic [32:0] LIMIT = 33'(DEPTH);

    logic [31:0] rel;
    logic [32:0] span_end;

    always_comb begin
        rel      = addr - BASE;
        span_end = {1'b0, rel} + {1'b0, size};
        ok       = ({1'b0, rel} <= LIMIT) && (span_end <= LIMIT);
        off      = rel[IW-1:0];
        len      = size[IW-1:0];
    end
endmodule

// File: rtl/cbs_ram.sv
module cbs_ram #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/cbs_ctrl.sv
module cbs_ctrl
    import cbs_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH),
    parameter int IW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          win_ok,
    input  logic [IW-1:0] cmd_off,
    input  logic [IW-1:0] cmd_len,
    input  logic [IW-1:0] rsp_off,
    input  logic [IW-1:0] rsp_len,
    input  logic          cmd_ready,
    input  logic          rsp_valid,
    input  logic [7:0]    rsp_data,
    input  logic          rsp_last,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          cmd_valid,
    output logic [7:0]    cmd_data,
    output logic          cmd_last,
    output logic          rsp_ready,
    output logic          eng_we,
    output logic [AW-1:0] eng_addr,
    output logic [7:0]    eng_wdata
);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    typedef struct packed {
        phase_e        phase;
        logic [IW-1:0] c_off;
        logic [IW-1:0] c_len;
        logic [IW-1:0] r_off;
        logic [IW-1:0] r_len;
        logic [IW-1:0] idx;
        logic          err;
        logic          done;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [IW-1:0] c_ptr, r_ptr;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        c_ptr     = st_q.c_off + st_q.idx;
        r_ptr     = st_q.r_off + st_q.idx;
        eng_we    = 1'b0;
        eng_addr  = '0;
        eng_wdata = 8'h00;
        cmd_valid = 1'b0;
        cmd_last  = 1'b0;
        rsp_ready = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (go) begin
                    if (!win_ok) begin
                        st_d.err  = 1'b1;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.err   = 1'b0;
                        st_d.c_off = cmd_off;
                        st_d.c_len = cmd_len;
                        st_d.r_off = rsp_off;
                        st_d.r_len = rsp_len;
                        st_d.idx   = '0;
                        st_d.phase = (cmd_len == '0) ? PH_SCRUB : PH_CMD_RD;
                    end
                end
            end
            PH_CMD_RD: begin
                eng_addr   = c_ptr[AW-1:0];
                st_d.phase = PH_CMD_TX;
            end
            PH_CMD_TX: begin
                eng_addr  = c_ptr[AW-1:0];
                cmd_valid = 1'b1;
                cmd_last  = (st_q.idx == st_q.c_len - IW'(1));
                if (cmd_ready) begin
                    if (cmd_last) begin
                        st_d.idx   = '0;
                        st_d.phase = PH_SCRUB;
                    end else begin
                        st_d.idx   = st_q.idx + IW'(1);
                        st_d.phase = PH_CMD_RD;
                    end
                end
            end
            PH_SCRUB: begin
                eng_we   = 1'b1;
                eng_addr = st_q.idx[AW-1:0];
                if (st_q.idx == LAST_IDX) begin
                    st_d.idx   = '0;
                    st_d.phase = PH_RSP;
                end else begin
                    st_d.idx = st_q.idx + IW'(1);
                end
            end
            PH_RSP: begin
                rsp_ready = 1'b1;
                eng_addr  = r_ptr[AW-1:0];
                if (rsp_valid) begin
                    if (st_q.idx < st_q.r_len) begin
                        eng_we    = 1'b1;
                        eng_wdata = rsp_data;
                        st_d.idx  = st_q.idx + IW'(1);
                    end
                    if (rsp_last) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign done     = st_q.done;
    assign err      = st_q.err;
    assign cmd_data = mem_rdata;
endmodule

// File: rtl/cbs_seq.sv
module cbs_seq #(
    parameter logic [31:0] BASE  = 32'hFED4_0080,
    parameter int          DEPTH = 128,
    localparam int         AW    = $clog2(DEPTH),
    localparam int         IW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [31:0]   cmd_size,
    input  logic [31:0]   cmd_addr,
    input  logic [31:0]   rsp_size,
    input  logic [31:0]   rsp_addr,
    output logic          busy,
    output logic          done,
    output logic          err,
    input  logic          hst_we,
    input  logic [AW-1:0] hst_addr,
    input  logic [7:0]    hst_wdata,
    output logic [7:0]    hst_rdata,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [7:0]    cmd_data,
    output logic          cmd_last,
    input  logic          rsp_valid,
    output logic          rsp_ready,
    input  logic [7:0]    rsp_data,
    input  logic          rsp_last
);
    logic [1:0]    ok_v;
    logic [IW-1:0] off_v [2];
    logic [IW-1:0] len_v [2];
    logic [31:0]   w_addr [2];
    logic [31:0]   w_size [2];

    assign w_addr[0] = cmd_addr;
    assign w_size[0] = cmd_size;
    assign w_addr[1] = rsp_addr;
    assign w_size[1] = rsp_size;

    for (genvar g = 0; g < 2; g++) begin : g_win
        cbs_window #(.BASE(BASE), .DEPTH(DEPTH), .IW(IW)) u_win (
            .addr (w_addr[g]),
            .size (w_size[g]),
            .ok   (ok_v[g]),
            .off  (off_v[g]),
            .len  (len_v[g])
        );
    end

    logic          eng_we;
    logic [AW-1:0] eng_addr;
    logic [7:0]    eng_wdata, eng_rdata;
    logic          host_we_ok;

    assign host_we_ok = hst_we && !busy;

    cbs_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk     (clk),
        .a_we    (host_we_ok),
        .a_addr  (hst_addr),
        .a_wdata (hst_wdata),
        .a_rdata (hst_rdata),
        .b_we    (eng_we),
        .b_addr  (eng_addr),
        .b_wdata (eng_wdata),
        .b_rdata (eng_rdata)
    );

    cbs_ctrl #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .win_ok    (&ok_v),
        .cmd_off   (off_v[0]),
        .cmd_len   (len_v[0]),
        .rsp_off   (off_v[1]),
        .rsp_len   (len_v[1]),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last),
        .mem_rdata (eng_rdata),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_last  (cmd_last),
        .rsp_ready (rsp_ready),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata)
    );
endmodule

// File: rtl/cbs_chk.sv
module cbs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_data,
    input logic       cmd_last,
    input logic       rsp_ready
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data) && $stable(cmd_last)));
    // R2
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);
    // R6
    rsp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (busy && !cmd_valid));
endmodule

bind cbs_seq cbs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .cmd_last  (cmd_last),
    .rsp_ready (rsp_ready)
);

// File: tb/sim_cbs_seq.sv
module sim_cbs_seq;
    localparam logic [31:0] BASE  = 32'hFED4_0080;
    localparam int          DEPTH = 128;
    localparam int          AW    = $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
    logic [31:0] cmd_size = '0, cmd_addr = '0, rsp_size = '0, rsp_addr = '0;
    logic busy, done, err;
    logic hst_we = 1'b0;
    logic [AW-1:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0, hst_rdata;
    logic cmd_valid, cmd_ready = 1'b0, cmd_last;
    logic [7:0] cmd_data;
    logic rsp_valid = 1'b0, rsp_ready, rsp_last = 1'b0;
    logic [7:0] rsp_data = '0;

    int tests = 0, fails = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] rbytes [DEPTH + 4];

    always #2ns clk = ~clk;

    cbs_seq #(.BASE(BASE), .DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit win_ok(input logic [31:0] a, input logic [31:0] s);
        logic [31:0] o;
        o = a - BASE;
        return (o <= 32'(DEPTH)) && (({1'b0, o} + {1'b0, s}) <= 33'(DEPTH));
    endfunction

    task automatic fill();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            hst_we = 1'b1; hst_addr = AW'(i); hst_wdata = 8'($urandom);
            model[i] = hst_wdata;
        end
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic readback(input string req);
        int bad = 0, first = -1, av = 0, ev = 0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk); hst_addr = AW'(i);
            @(negedge clk);
            if (hst_rdata !== model[i]) begin
                bad++;
                if (first < 0) begin first = i; av = int'(hst_rdata); ev = int'(model[i]); end
            end
        end
        chk(bad == 0, req, $sformatf("buffer byte %0d", first), av, ev);
    endtask

    task automatic txn(input logic [31:0] ca, input logic [31:0] cs,
                       input logic [31:0] ra, input logic [31:0] rs, input int nresp);
        bit ok, inj_c = 0, inj_r = 0, seen_done = 0;
        int co, ro, got = 0, mism = 0, lastbad = 0, sent = 0, cyc = 0, keep;
        ok = win_ok(ca, cs) && win_ok(ra, rs);
        co = int'(ca - BASE); ro = int'(ra - BASE);
        for (int i = 0; i < nresp; i++) rbytes[i] = 8'($urandom);
        fill();
        @(negedge clk);
        cmd_addr = ca; cmd_size = cs; rsp_addr = ra; rsp_size = rs; go = 1'b1;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            go = 1'b0; cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_last = 1'b0; hst_we = 1'b0;
            if (done) begin seen_done = 1; break; end
            if (cmd_valid) begin
                if (!inj_c) begin
                    inj_c = 1; hst_we = 1'b1;
                    hst_addr = AW'(co + int'(cs) - 1);
                    hst_wdata = ~model[co + int'(cs) - 1];
                end
                if ($urandom % 3 != 0) begin
                    cmd_ready = 1'b1;
                    if (cmd_data !== model[co + got]) mism++;
                    if (cmd_last !== (got == int'(cs) - 1)) lastbad++;
                    got++;
                end
            end else if (rsp_ready) begin
                if (!inj_r) begin
                    inj_r = 1; hst_we = 1'b1; hst_addr = AW'($urandom);
                    hst_wdata = 8'hA5; go = 1'b1;
                end
                if (sent < nresp && ($urandom % 2 == 0)) begin
                    rsp_valid = 1'b1; rsp_data = rbytes[sent];
                    rsp_last = (sent == nresp - 1); sent++;
                end
            end
        end
        chk(seen_done, "R7", "done seen", int'(seen_done), 1);
        chk(err === !ok, "R1", "err after done", int'(err), int'(!ok));
        if (ok) begin
            chk(got == int'(cs) && mism == 0 && lastbad == 0, "R2",
                $sformatf("cmd bytes (mism %0d, last %0d, inj %0d) R4", mism, lastbad, inj_c),
                got, int'(cs));
            for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
            keep = (nresp < int'(rs)) ? nresp : int'(rs);
            for (int i = 0; i < keep; i++) model[ro + i] = rbytes[i];
        end else begin
            chk(got == 0, "R1", "backend bytes on rejected request", got, 0);
        end
        repeat (4) begin
            @(negedge clk);
            chk(!busy && !done, "R8", "idle after done", int'(busy) + 2 * int'(done), 0);
        end
        readback(ok ? "R5_R6" : "R1");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid && !rsp_ready, "R9", "reset outputs",
            int'({busy, done, err, cmd_valid, rsp_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R6: full windows, exact response length
        txn(BASE, DEPTH, BASE, DEPTH, DEPTH);
        // R2: zero-length command at the very end; R6 short response stays zero
        txn(BASE + DEPTH, 0, BASE + 10, 20, 5);
        // R6: extra response bytes dropped
        txn(BASE + 5, 7, BASE + 100, 8, 12);
        // R1: offset past end
        txn(BASE + DEPTH + 1, 0, BASE, 4, 1);
        // R1: window end one past buffer
        txn(BASE + 3, DEPTH - 2, BASE, 4, 1);
        // R1: response address below base (wraps)
        txn(BASE, 4, BASE - 1, 1, 1);
        // R7: err cleared by a valid request
        txn(BASE + 1, 3, BASE + 2, 0, 2);
        chk(!err, "R7", "err cleared", int'(err), 0);
        for (int n = 0; n < 14; n++) begin
            int co = $urandom % (DEPTH + 1);
            int cl = $urandom % (DEPTH + 1 - co);
            int ro = $urandom % (DEPTH + 1);
            int rl = $urandom % (DEPTH + 1 - ro);
            if (n % 5 == 4) co = DEPTH + 1 + ($urandom % 4);
            txn(BASE + 32'(co), 32'(cl), BASE + 32'(ro), 32'(rl), 1 + int'($urandom % (rl + 3)));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4ns * 190000);
        fails++; tests++;
        $display("FAIL R7 watchdog: actual no completion expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule